// File: doc/BRIEF.md
# Two-Wire Slave Configuration Port

This block is the configuration port of a modulator. An external processor reaches the register set over a two-wire bus: one open-drain clock line and one open-drain data line, with START and STOP conditions, a 7-bit device address followed by a read/write bit, and a ninth clock bit for acknowledge. The block is a slave and nothing else. It never drives the clock, never stretches it, and takes part in no arbitration. Both bus lines pass through two-flop synchronisers and are sampled by the system clock. The block drives the data line only through an active-high pull-low enable.

Five bits of the device address are fixed. The lowest two come from a pair of strap inputs, so up to four of these devices can share one bus. The first byte of every write transfer names a register group. Only two groups exist, and each holds 128 byte registers. A transfer that names any other group is refused and has no effect. For a valid group, the next byte loads a register pointer. Each data byte after that is written at the pointer and moves it on by one. A read transfer returns bytes from the most recently selected group, starting at the pointer and advancing it.

Top module: `sbus_reg_slave`

## Requirements
- R1: The block acknowledges an address byte, by pulling the data line low during the ninth clock, only when bits 7..3 of the byte equal 11010 and bits 2..1 equal `base_sel`. Bit 0 of the address byte is the direction: 0 means write, 1 means read.
- R2: After an address byte that does not match, the block acknowledges nothing and leaves the data line released until the next START.
- R3: In a write transfer, bits 2..0 of the first byte after the address select the group. The values 0 and 2 are acknowledged and bits 7..3 are ignored.
- R4: When any other group value is given, the block refuses that byte and every later byte of the transfer. It changes no register, and it keeps the previously selected group and pointer.
- R5: For a valid group, bits 6..0 of the second byte load the register pointer and bit 7 is ignored.
- R6: Each later byte of a write transfer is stored at the pointer and is acknowledged. The pointer then increments and wraps from 127 to 0.
- R7: Group 0 and group 2 are separate 128-byte banks. A write to one never changes the other.
- R8: In a read transfer the block sends, MSB first, the register of the selected group at the pointer, then increments the pointer. It continues while the master acknowledges. After a master not-acknowledge it releases the line until the next START.
- R9: A STOP at any point returns the block to idle with the line released. A START at any point, including a repeated START, begins a new address phase. The group and pointer are kept across both.
- R10: During and after reset the data line is released and the block waits for a START.
- R11: The block starts or changes its drive of the data line only right after a detected falling clock edge. It releases the line early only on a START, a STOP or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples both bus lines |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 2 | Strap inputs giving device address bits 1..0 |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High to pull the data line low (open drain) |

## Verification
The bench builds the block with its default parameters. These are a 7-bit register pointer, 8-bit data and two synchroniser stages, which makes the 127-to-0 pointer wrap reachable within two data bytes. It drives the bus at twelve system clocks per half period of the bus clock, so the synchroniser and edge-detect delay sits well inside each bus phase. A behavioural model of both banks, the pointer and the group predicts every acknowledge and every read byte. On every clock, the bench compares the data-line drive against the windows in which the model allows the slave to drive.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_ID_HI = 5'b11010;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RHOLD, S_RACK, S_TX, S_TACK, S_WAIT
  } sbus_state_t;

  typedef enum logic [1:0] {
    B_ADDR, B_GRP, B_REG, B_DATA
  } sbus_role_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic scl_q, sda_q;

  assign raw = {scl_in, sda_in};

  for (genvar i = 0; i < 2; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      sda_lvl   <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_q     <= synced[1];
      sda_q     <= synced[0];
      sda_lvl   <= synced[0];
      scl_rise  <= synced[1] & ~scl_q;
      scl_fall  <= ~synced[1] & scl_q;
      start_det <= synced[1] & scl_q & sda_q & ~synced[0];
      stop_det  <= synced[1] & scl_q & ~sda_q & synced[0];
    end
  end
endmodule

// File: rtl/sbus_regbank.sv
module sbus_regbank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbus_engine.sv
module sbus_engine
  import sbus_pkg::*;
#(
  parameter int REG_AW = 7,
  localparam int MEM_AW = REG_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        base_sel,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [MEM_AW-1:0] mem_raddr,
  output logic              sda_oe
);
  sbus_state_t       st;
  sbus_role_t        rl;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic [2:0]        bit_cnt;
  logic              rw, bank, ack_ok, m_ack;
  logic [REG_AW-1:0] ptr;
  logic [BYTE_W-1:0] rx_byte;
  logic              grp_ok;

  assign rx_byte   = {rx_sr[BYTE_W-2:0], sda_lvl};
  assign grp_ok    = (rx_byte[2:0] == 3'd0) || (rx_byte[2:0] == 3'd2);
  assign mem_raddr = {bank, ptr};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; rl <= B_ADDR; rx_sr <= '0; tx_sr <= '0; bit_cnt <= '0;
      rw <= 1'b0; bank <= 1'b0; ack_ok <= 1'b0; m_ack <= 1'b0; ptr <= '0;
      mem_we <= 1'b0; mem_waddr <= '0; mem_wdata <= '0; sda_oe <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (start_det) begin
        st <= S_RX; rl <= B_ADDR; bit_cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            rx_sr   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              st <= S_RHOLD;
              case (rl)
                B_ADDR: begin
                  ack_ok <= (rx_byte[7:1] == {DEV_ID_HI, base_sel});
                  rw     <= rx_byte[0];
                end
                B_GRP: begin
                  ack_ok <= grp_ok;
                  if (grp_ok) bank <= rx_byte[1];
                end
                B_REG: begin
                  ack_ok <= 1'b1;
                  ptr    <= rx_byte[REG_AW-1:0];
                end
                default: begin
                  ack_ok    <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_waddr <= {bank, ptr};
                  mem_wdata <= rx_byte;
                  ptr       <= ptr + 1'b1;
                end
              endcase
            end
          end
          S_RHOLD: if (scl_fall) begin
            if (ack_ok) begin sda_oe <= 1'b1; st <= S_RACK; end
            else st <= S_WAIT;
          end
          S_RACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rl == B_ADDR && rw) begin
              sda_oe <= ~mem_rdata[BYTE_W-1];
              tx_sr  <= {mem_rdata[BYTE_W-2:0], 1'b0};
              ptr    <= ptr + 1'b1;
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
              case (rl)
                B_ADDR:  rl <= B_GRP;
                B_GRP:   rl <= B_REG;
                default: rl <= B_DATA;
              endcase
            end
          end
          S_TX: if (scl_fall) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0; st <= S_TACK;
            end else begin
              sda_oe <= ~tx_sr[BYTE_W-1];
              tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
          end
          S_TACK: begin
            if (scl_rise) m_ack <= ~sda_lvl;
            if (scl_fall) begin
              bit_cnt <= '0;
              if (m_ack) begin
                sda_oe <= ~mem_rdata[BYTE_W-1];
                tx_sr  <= {mem_rdata[BYTE_W-2:0], 1'b0};
                ptr    <= ptr + 1'b1;
                st     <= S_TX;
              end else st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sbus_reg_slave.sv
module sbus_reg_slave
  import sbus_pkg::*;
#(
  parameter int REG_AW      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] base_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe
);
  localparam int MEM_AW = REG_AW + 1;

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic mem_we;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  sbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sbus_engine #(.REG_AW(REG_AW)) u_engine (
    .clk(clk), .rst(rst), .base_sel(base_sel), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr),
    .sda_oe(sda_oe)
  );

  sbus_regbank #(.AW(MEM_AW), .DW(BYTE_W)) u_bank (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/sbus_reg_slave_chk.sv
module sbus_reg_slave_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det
);
  // R10
  reset_release_chk: assert property (@(posedge clk) rst |=> !sda_oe);
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);
  // R11
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R11
  change_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind sbus_reg_slave sbus_reg_slave_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det)
);

// File: tb/sbus_reg_slave_tb.sv
module sbus_reg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] base_sel = 2'b10;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic allow = 1'b0;
  logic mon_en = 1'b0;
  wire  sda_oe;
  wire  sda_line = ~(m_low | sda_oe);

  int vectors = 0;
  int errors = 0;
  int mem [int];
  int m_ptr = 0;
  int m_grp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_reg_slave u_dut (
    .clk(clk), .rst(rst), .base_sel(base_sel),
    .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  // R2 and R11: per-clock comparison of the drive against the model window
  always @(negedge clk) if (mon_en) begin
    vectors++;
    if (sda_oe && !allow) begin
      errors++;
      $display("FAIL R11/R2: sda_oe actual 1 expected 0 at %0t", $time);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] b, input logic rd);
    return {5'b11010, b, rd};
  endfunction

  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                           input logic hold, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) allow = exp_ack;
      put_bit(b[i]);
    end
    m_low = 1'b0; wq(); scl = 1'b1; wq(); a = ~sda_line; wq(); scl = 1'b0; wq();
    if (!hold) allow = 1'b0;
    chk(req, int'(a), int'(exp_ack));
  endtask

  task automatic read_byte(input int exp, input logic mack, input string req);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; wq(); scl = 1'b1; wq(); v[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    m_low = mack; wq(); allow = 1'b0; scl = 1'b1; wq(); wq();
    scl = 1'b0; allow = mack; wq();
    chk(req, int'(v), exp);
  endtask

  task automatic wr_txn(input logic [7:0] gb, input logic [7:0] rb,
                        input logic [7:0] data [$], input string req);
    logic ok;
    ok = (gb[2:0] == 3'd0) || (gb[2:0] == 3'd2);
    bus_start();
    send_byte(dev(base_sel, 1'b0), 1'b1, 1'b0, "R1");
    send_byte(gb, ok, 1'b0, ok ? "R3" : "R4");
    send_byte(rb, ok, 1'b0, ok ? "R5" : "R4");
    if (ok) begin m_grp = gb[1]; m_ptr = rb[6:0]; end
    foreach (data[i]) begin
      send_byte(data[i], ok, 1'b0, ok ? req : "R4");
      if (ok) begin
        mem[m_grp*128 + m_ptr] = data[i];
        m_ptr = (m_ptr + 1) % 128;
      end
    end
    bus_stop();
  endtask

  task automatic rd_body(input int n, input string req);
    send_byte(dev(base_sel, 1'b1), 1'b1, 1'b1, "R8");
    for (int i = 0; i < n; i++) begin
      read_byte(mem.exists(m_grp*128 + m_ptr) ? mem[m_grp*128 + m_ptr] : -1,
                (i < n-1), req);
      m_ptr = (m_ptr + 1) % 128;
    end
    bus_stop();
  endtask

  task automatic rd_txn(input int n, input string req);
    bus_start();
    rd_body(n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] q [$];
    repeat (5) @(negedge clk);
    chk("R10", int'(sda_oe), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    chk("R10", int'(sda_oe), 0);

    // R6 basic write to group 0, R7 write to group 2
    q = {8'hAA, 8'h55, 8'h3C}; wr_txn(8'h00, 8'h05, q, "R6");
    q = {8'h11, 8'h22};        wr_txn(8'h02, 8'h05, q, "R7");
    // R4 unsupported group 3 refused, nothing written
    q = {8'hFF};               wr_txn(8'h03, 8'h05, q, "R4");
    // R2 mismatched addresses: no acknowledge, no drive
    bus_start();
    send_byte({5'b11011, base_sel, 1'b0}, 1'b0, 1'b0, "R2");
    send_byte(8'h00, 1'b0, 1'b0, "R2");
    send_byte(8'h05, 1'b0, 1'b0, "R2");
    send_byte(8'hEE, 1'b0, 1'b0, "R2");
    bus_stop();
    bus_start();
    send_byte(dev(2'b01, 1'b0), 1'b0, 1'b0, "R2");
    bus_stop();
    // R3 upper group bits ignored, R5 pointer bit 7 ignored, R8 read
    q.delete(); wr_txn(8'h08, 8'h85, q, "R5");
    rd_txn(3, "R8");
    // R7 group 2 bank kept apart, unaffected by the refused group 3 write
    q.delete(); wr_txn(8'h02, 8'h05, q, "R5");
    rd_txn(2, "R7");
    // R6 pointer wrap 127 -> 0
    q = {8'h01, 8'h02}; wr_txn(8'h00, 8'h7F, q, "R6");
    q.delete(); wr_txn(8'h00, 8'h7F, q, "R5");
    rd_txn(2, "R6");
    // R9 repeated START turns a write into a read
    q = {8'h77, 8'h88}; wr_txn(8'h00, 8'h10, q, "R6");
    bus_start();
    send_byte(dev(base_sel, 1'b0), 1'b1, 1'b0, "R1");
    send_byte(8'h00, 1'b1, 1'b0, "R3");
    send_byte(8'h10, 1'b1, 1'b0, "R5");
    m_grp = 0; m_ptr = 8'h10;
    bus_start();
    rd_body(2, "R9");
    // R9 STOP in the middle of an address byte
    bus_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    chk("R9", int'(sda_oe), 0);
    q.delete(); wr_txn(8'h02, 8'h06, q, "R5");
    rd_txn(1, "R9");
    // R1 new strap value
    base_sel = 2'b01;
    repeat (4) @(negedge clk);
    q = {8'h5A}; wr_txn(8'h00, 8'h20, q, "R1");
    q.delete(); wr_txn(8'h00, 8'h20, q, "R1");
    rd_txn(1, "R1");
    bus_start();
    send_byte(dev(2'b10, 1'b0), 1'b0, 1'b0, "R2");
    bus_stop();

    mon_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule